// File: doc/BRIEF.md
# Banked Masked Control-Register File

This block holds the system control registers of a multithreaded core. Each register is addressed by an 8-bit index that joins a 5-bit register number with a 3-bit select, as `{number, select}`, so the index equals number*8 + select. Each implemented register is stored in one of three ways. A shared register has a single copy for the whole processor. A per-VPE register has one copy per virtual processing element. A per-thread register has one copy per thread context.

A requesting thread id picks the bank. For a per-thread register the bank is the thread id itself. For a per-VPE register the bank is the VPE number held in that thread's binding register. A software write changes only the bits that the register's write mask allows, so read-only fields keep their values. A separate direct-write port, meant for hardware status updates, writes all 32 bits and wins over a software write to the same copy. Reads are combinational.

Top module: `banked_ctl_regfile`

## Requirements
- R1: A software write stores (data & mask) | (old & ~mask) into the addressed copy at the next rising clock edge. Bits whose mask bit is 0 keep their old value.
- R2: Software writes have no effect on the processor id (15,0), Config1 (16,1), Config3 (16,3), Random (1,0), the bad-address register (8,0) or the link-address register (17,0). Each of these has a zero write mask.
- R3: An index that holds no register reads as zero, and writes to it are discarded. Examples are 56 (7,0), 200 and 255.
- R4: Per-thread registers (Status 12,0; thread registers 2,1 to 2,7; the link-address register 17,0; Debug 23,0) keep one copy per thread, selected by the thread id.
- R5: Per-VPE registers (1,1 to 1,7; 6,1 to 6,5; the exception base 15,1) select their copy from bits [VPE_W-1:0] of the requesting thread's binding register (2,2). The binding register is per-thread with an all-ones mask.
- R6: Shared registers hold one copy. A write from any thread is seen by every thread.
- R7: Reset values are as follows. Status is 0x00400004, which sets bit 22 and bit 2. Random is 63. The exception base is 0x80000000. Config (16,0) is 0x80000000. Every other register resets to 0.
- R8: Write masks are as follows. Status 0xFF78FF17; Cause (13,0) 0x08C00300; Index (0,0) 0x7FFFFFFF; EntryLo (2,0 and 3,0) 0x3FFFFFFF; Context (4,0) 0xFF800000; PageMask (5,0) 0x1FFFF800; PageGrain (5,1) 0x10000000; exception base 0x3FFFF000; shadow control (12,2) 0x0000F3C0; interrupt control (12,1) 0x000003E0; Config 0x7FFF0007; Config2 (16,2) 0x7000F000. All registers not named here or in R2 use an all-ones mask.
- R9: A direct write stores all 32 bits of its data, whatever the mask.
- R10: When both ports target the same copy in one cycle, the direct-write data is stored. When they target different copies, both writes take effect.
- R11: The read data follows the read index and thread id in the same cycle. It does not change while no write happens and the read inputs are steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_idx | input | 8 | Read index {number, select} |
| rd_tid | input | TID_W | Thread id of the reader |
| rd_data | output | 32 | Read data |
| sw_en | input | 1 | Software (masked) write enable |
| sw_idx | input | 8 | Software write index |
| sw_tid | input | TID_W | Thread id of the software writer |
| sw_data | input | 32 | Software write data |
| dw_en | input | 1 | Direct (unmasked) write enable |
| dw_idx | input | 8 | Direct write index |
| dw_tid | input | TID_W | Thread id of the direct writer |
| dw_data | input | 32 | Direct write data |

## Verification
All-ones and all-zeros software writes go to the masked registers. Reading them back separates the writable bits from the preserved ones, and a wrong or missing mask shows up right away. The same register is written from one thread and read from others. This separates the per-thread, per-VPE and shared cases, and it shows whether changing a binding register moves a thread onto another VPE copy. Randomly ordered mixed writes from both ports are compared with a reference model. They cover unused indices and collisions on one copy, which separate the direct-write priority from the plain merge.

// File: rtl/ctlrf_pkg.sv
package ctlrf_pkg;
   localparam int DW    = 32;
   localparam int IDX_W = 8;
   localparam logic [DW-1:0] ONES = '1;
   localparam logic [IDX_W-1:0] BIND_IDX = 8'd18;

   typedef enum logic [1:0] {BK_NONE, BK_SHARED, BK_VPE, BK_TC} bank_kind_e;

   typedef struct packed {
      bank_kind_e    kind;
      logic [DW-1:0] rst;
      logic [DW-1:0] mask;
   } reg_info_t;

   function automatic reg_info_t reg_info(input logic [IDX_W-1:0] idx);
      reg_info_t r;
      r = '{BK_NONE, '0, '0};
      case (idx)
         8'd0:   r = '{BK_SHARED, 32'h0, 32'h7FFF_FFFF};
         8'd8:   r = '{BK_SHARED, 32'd63, 32'h0};
         8'd9, 8'd10, 8'd11, 8'd12, 8'd13, 8'd14, 8'd15,
         8'd49, 8'd50, 8'd51, 8'd52, 8'd53:
                 r = '{BK_VPE, 32'h0, ONES};
         8'd16, 8'd24:
                 r = '{BK_SHARED, 32'h0, 32'h3FFF_FFFF};
         8'd17, 8'd18, 8'd19, 8'd20, 8'd21, 8'd22, 8'd23, 8'd184:
                 r = '{BK_TC, 32'h0, ONES};
         8'd32:  r = '{BK_SHARED, 32'h0, 32'hFF80_0000};
         8'd40:  r = '{BK_SHARED, 32'h0, 32'h1FFF_F800};
         8'd41:  r = '{BK_SHARED, 32'h0, 32'h1000_0000};
         8'd48, 8'd112:
                 r = '{BK_SHARED, 32'h0, ONES};
         8'd64, 8'd120, 8'd129, 8'd131:
                 r = '{BK_SHARED, 32'h0, 32'h0};
         8'd96:  r = '{BK_TC, 32'h0040_0004, 32'hFF78_FF17};
         8'd97:  r = '{BK_SHARED, 32'h0, 32'h0000_03E0};
         8'd98:  r = '{BK_SHARED, 32'h0, 32'h0000_F3C0};
         8'd104: r = '{BK_SHARED, 32'h0, 32'h08C0_0300};
         8'd121: r = '{BK_VPE, 32'h8000_0000, 32'h3FFF_F000};
         8'd128: r = '{BK_SHARED, 32'h8000_0000, 32'h7FFF_0007};
         8'd130: r = '{BK_SHARED, 32'h0, 32'h7000_F000};
         8'd136: r = '{BK_TC, 32'h0, 32'h0};
         default: r = '{BK_NONE, '0, '0};
      endcase
      return r;
   endfunction
endpackage

// File: rtl/ctlrf_bank_sel.sv
module ctlrf_bank_sel
   import ctlrf_pkg::*;
#(
   parameter int NUM_TC  = 4,
   parameter int NUM_VPE = 2,
   parameter int TID_W   = 2,
   parameter int VPE_W   = 1,
   parameter int BANK_W  = 2
) (
   input  logic [IDX_W-1:0]              idx,
   input  logic [TID_W-1:0]              tid,
   input  logic [NUM_TC-1:0][VPE_W-1:0]  tc_vpe,
   output logic [BANK_W-1:0]             bank
);
   bank_kind_e       kind;
   logic [VPE_W-1:0] vpe_bank;

   assign kind = reg_info(idx).kind;

   generate
      if (NUM_VPE == 1) begin : g_one_vpe
         assign vpe_bank = '0;
      end else begin : g_multi_vpe
         assign vpe_bank = tc_vpe[tid];
      end
   endgenerate

   always_comb begin
      case (kind)
         BK_TC:   bank = BANK_W'(tid);
         BK_VPE:  bank = BANK_W'(vpe_bank);
         default: bank = '0;
      endcase
   end
endmodule

// File: rtl/ctlrf_cell.sv
module ctlrf_cell #(
   parameter int              DW      = 32,
   parameter logic [DW-1:0]   RST_VAL = '0,
   parameter logic [DW-1:0]   WMASK   = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sw_we,
   input  logic [DW-1:0] sw_data,
   input  logic          dw_we,
   input  logic [DW-1:0] dw_data,
   output logic [DW-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= RST_VAL;
      else if (dw_we)
         q <= dw_data;
      else if (sw_we)
         q <= (sw_data & WMASK) | (q & ~WMASK);
   end
endmodule

// File: rtl/banked_ctl_regfile.sv
module banked_ctl_regfile
   import ctlrf_pkg::*;
#(
   parameter int NUM_TC  = 4,
   parameter int NUM_VPE = 2,
   localparam int TID_W  = $clog2(NUM_TC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [TID_W-1:0] rd_tid,
   output logic [DW-1:0]    rd_data,
   input  logic             sw_en,
   input  logic [IDX_W-1:0] sw_idx,
   input  logic [TID_W-1:0] sw_tid,
   input  logic [DW-1:0]    sw_data,
   input  logic             dw_en,
   input  logic [IDX_W-1:0] dw_idx,
   input  logic [TID_W-1:0] dw_tid,
   input  logic [DW-1:0]    dw_data
);
   localparam int VPE_W  = (NUM_VPE > 1) ? $clog2(NUM_VPE) : 1;
   localparam int MAXB   = (NUM_TC > NUM_VPE) ? NUM_TC : NUM_VPE;
   localparam int BANK_W = $clog2(MAXB);
   localparam int NREG   = 1 << IDX_W;

   generate
      if (NUM_TC < 2) begin : g_bad_tc
         $error("NUM_TC must be at least 2");
      end
      if ((NUM_VPE < 1) || ((NUM_VPE & (NUM_VPE - 1)) != 0)) begin : g_bad_vpe
         $error("NUM_VPE must be a power of two");
      end
      if (NUM_VPE > NUM_TC) begin : g_vpe_gt_tc
         $error("NUM_VPE must not exceed NUM_TC");
      end
   endgenerate

   logic [DW-1:0]             q [NREG][MAXB];
   logic [NUM_TC-1:0][VPE_W-1:0] tc_vpe;
   logic [BANK_W-1:0]         rd_bank, sw_bank, dw_bank;
   logic                      rd_valid;

   generate
      for (genvar t = 0; t < NUM_TC; t++) begin : g_bind
         assign tc_vpe[t] = q[BIND_IDX][t][VPE_W-1:0];
      end
   endgenerate

   ctlrf_bank_sel #(.NUM_TC(NUM_TC), .NUM_VPE(NUM_VPE), .TID_W(TID_W),
                    .VPE_W(VPE_W), .BANK_W(BANK_W))
      u_rd_sel (.idx(rd_idx), .tid(rd_tid), .tc_vpe(tc_vpe), .bank(rd_bank));
   ctlrf_bank_sel #(.NUM_TC(NUM_TC), .NUM_VPE(NUM_VPE), .TID_W(TID_W),
                    .VPE_W(VPE_W), .BANK_W(BANK_W))
      u_sw_sel (.idx(sw_idx), .tid(sw_tid), .tc_vpe(tc_vpe), .bank(sw_bank));
   ctlrf_bank_sel #(.NUM_TC(NUM_TC), .NUM_VPE(NUM_VPE), .TID_W(TID_W),
                    .VPE_W(VPE_W), .BANK_W(BANK_W))
      u_dw_sel (.idx(dw_idx), .tid(dw_tid), .tc_vpe(tc_vpe), .bank(dw_bank));

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_reg
         localparam reg_info_t INF = reg_info(IDX_W'(i));
         localparam int NB = (INF.kind == BK_TC)     ? NUM_TC  :
                             (INF.kind == BK_VPE)    ? NUM_VPE :
                             (INF.kind == BK_SHARED) ? 1 : 0;
         for (genvar b = 0; b < MAXB; b++) begin : g_bank
            if (b < NB) begin : g_cell
               logic sw_we, dw_we;
               assign sw_we = sw_en && (sw_idx == IDX_W'(i)) && (sw_bank == BANK_W'(b));
               assign dw_we = dw_en && (dw_idx == IDX_W'(i)) && (dw_bank == BANK_W'(b));
               ctlrf_cell #(.DW(DW), .RST_VAL(INF.rst), .WMASK(INF.mask)) u_cell (
                  .clk(clk), .rst_n(rst_n),
                  .sw_we(sw_we), .sw_data(sw_data),
                  .dw_we(dw_we), .dw_data(dw_data),
                  .q(q[i][b]));
            end else begin : g_empty
               assign q[i][b] = '0;
            end
         end
      end
   endgenerate

   assign rd_valid = (reg_info(rd_idx).kind != BK_NONE);
   assign rd_data  = q[rd_idx][rd_bank];
endmodule

// File: rtl/ctlrf_checker.sv
module ctlrf_checker
   import ctlrf_pkg::*;
#(
   parameter int NUM_TC  = 4,
   parameter int NUM_VPE = 2,
   localparam int TID_W  = $clog2(NUM_TC),
   localparam int MAXB   = (NUM_TC > NUM_VPE) ? NUM_TC : NUM_VPE,
   localparam int BANK_W = $clog2(MAXB),
   localparam int NREG   = 1 << IDX_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [IDX_W-1:0]  rd_idx,
   input logic [TID_W-1:0]  rd_tid,
   input logic [DW-1:0]     rd_data,
   input logic              rd_valid,
   input logic              sw_en,
   input logic [IDX_W-1:0]  sw_idx,
   input logic [DW-1:0]     sw_data,
   input logic [BANK_W-1:0] sw_bank,
   input logic              dw_en,
   input logic [IDX_W-1:0]  dw_idx,
   input logic [DW-1:0]     dw_data,
   input logic [BANK_W-1:0] dw_bank,
   input logic [DW-1:0]     q [NREG][MAXB]
);
   logic              sw_ok, dw_ok, same_copy;
   logic              pend_sw, pend_dw;
   logic [IDX_W-1:0]  sv_sw_idx, sv_dw_idx;
   logic [BANK_W-1:0] sv_sw_bank, sv_dw_bank;
   logic [DW-1:0]     sv_sw_exp, sv_dw_exp;
   logic [DW-1:0]     sw_mask;

   assign sw_ok     = sw_en && (reg_info(sw_idx).kind != BK_NONE);
   assign dw_ok     = dw_en && (reg_info(dw_idx).kind != BK_NONE);
   assign same_copy = (sw_idx == dw_idx) && (sw_bank == dw_bank);
   assign sw_mask   = reg_info(sw_idx).mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_sw    <= 1'b0;
         pend_dw    <= 1'b0;
         sv_sw_idx  <= '0;
         sv_dw_idx  <= '0;
         sv_sw_bank <= '0;
         sv_dw_bank <= '0;
         sv_sw_exp  <= '0;
         sv_dw_exp  <= '0;
      end else begin
         pend_sw    <= sw_ok && !(dw_ok && same_copy);
         pend_dw    <= dw_ok;
         sv_sw_idx  <= sw_idx;
         sv_sw_bank <= sw_bank;
         sv_sw_exp  <= (sw_data & sw_mask) | (q[sw_idx][sw_bank] & ~sw_mask);
         sv_dw_idx  <= dw_idx;
         sv_dw_bank <= dw_bank;
         sv_dw_exp  <= dw_data;
      end
   end

   // R1
   masked_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_sw |-> q[sv_sw_idx][sv_sw_bank] == sv_sw_exp);

   // R10
   direct_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_dw |-> q[sv_dw_idx][sv_dw_bank] == sv_dw_exp);

   // R3
   unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> rd_data == '0);

   // R11
   read_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(rd_idx) && $stable(rd_tid) && !$past(sw_en) && !$past(dw_en))
      |-> $stable(rd_data));
endmodule

bind banked_ctl_regfile ctlrf_checker #(.NUM_TC(NUM_TC), .NUM_VPE(NUM_VPE)) u_chk (.*);

// File: tb/banked_ctl_regfile_test.sv
module banked_ctl_regfile_test;
   localparam int NTC = 4;
   localparam int TW  = 2;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  rd_idx, sw_idx, dw_idx;
   logic [TW-1:0] rd_tid, sw_tid, dw_tid;
   logic [31:0] rd_data, sw_data, dw_data;
   logic        sw_en, dw_en;

   int checks = 0;
   int errors = 0;
   logic [31:0] m [256][4];

   always #5 clk = ~clk;

   banked_ctl_regfile #(.NUM_TC(NTC), .NUM_VPE(2)) uut (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(rd_idx), .rd_tid(rd_tid), .rd_data(rd_data),
      .sw_en(sw_en), .sw_idx(sw_idx), .sw_tid(sw_tid), .sw_data(sw_data),
      .dw_en(dw_en), .dw_idx(dw_idx), .dw_tid(dw_tid), .dw_data(dw_data));

   // 0 none, 1 shared, 2 per-VPE, 3 per-thread
   function automatic int b_kind(input logic [7:0] i);
      if ((i >= 9 && i <= 15) || (i >= 49 && i <= 53) || i == 121) return 2;
      if ((i >= 17 && i <= 23) || i == 96 || i == 136 || i == 184) return 3;
      case (i)
         0, 8, 16, 24, 32, 40, 41, 48, 64, 97, 98, 104, 112,
         120, 128, 129, 130, 131: return 1;
         default: return 0;
      endcase
   endfunction

   function automatic logic [31:0] b_mask(input logic [7:0] i);
      case (i)
         0: return 32'h7FFFFFFF;   16, 24: return 32'h3FFFFFFF;
         32: return 32'hFF800000;  40: return 32'h1FFFF800;
         41: return 32'h10000000;  96: return 32'hFF78FF17;
         97: return 32'h000003E0;  98: return 32'h0000F3C0;
         104: return 32'h08C00300; 121: return 32'h3FFFF000;
         128: return 32'h7FFF0007; 130: return 32'h7000F000;
         8, 64, 120, 129, 131, 136: return 32'h0;
         default: return 32'hFFFFFFFF;
      endcase
   endfunction

   function automatic logic [31:0] b_rst(input logic [7:0] i);
      case (i)
         96: return 32'h00400004;
         8: return 32'd63;
         121, 128: return 32'h80000000;
         default: return 32'h0;
      endcase
   endfunction

   function automatic int b_bank(input logic [7:0] i, input logic [TW-1:0] t);
      case (b_kind(i))
         3: return int'(t);
         2: return int'(m[18][t][0]);
         default: return 0;
      endcase
   endfunction

   function automatic logic [31:0] b_read(input logic [7:0] i, input logic [TW-1:0] t);
      if (b_kind(i) == 0) return 32'h0;
      return m[i][b_bank(i, t)];
   endfunction

   function automatic logic [7:0] pick(input int n);
      case (n)
         0: return 0;    1: return 8;    2: return 9;    3: return 121;
         4: return 16;   5: return 18;   6: return 96;   7: return 104;
         8: return 120;  9: return 128;  10: return 130; 11: return 136;
         12: return 184; 13: return 56;  14: return 200; default: return 49;
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] i, input logic [TW-1:0] t,
                         input logic [31:0] exp);
      rd_idx = i;
      rd_tid = t;
      #1;
      check(tag, rd_data, exp);
   endtask

   task automatic cyc(input logic se, input logic [7:0] si, input logic [TW-1:0] st,
                      input logic [31:0] sd, input logic de, input logic [7:0] di,
                      input logic [TW-1:0] dt, input logic [31:0] dd);
      int sb, db;
      sw_en = se; sw_idx = si; sw_tid = st; sw_data = sd;
      dw_en = de; dw_idx = di; dw_tid = dt; dw_data = dd;
      @(posedge clk);
      sb = b_bank(si, st);
      db = b_bank(di, dt);
      if (se && b_kind(si) != 0)
         m[si][sb] = (sd & b_mask(si)) | (m[si][sb] & ~b_mask(si));
      if (de && b_kind(di) != 0)
         m[di][db] = dd;
      @(negedge clk);
      sw_en = 1'b0;
      dw_en = 1'b0;
   endtask

   task automatic swr(input logic [7:0] i, input logic [TW-1:0] t, input logic [31:0] d);
      cyc(1'b1, i, t, d, 1'b0, 8'd0, '0, 32'h0);
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0;
      sw_en = 0; dw_en = 0; sw_idx = 0; dw_idx = 0; sw_tid = 0; dw_tid = 0;
      sw_data = 0; dw_data = 0; rd_idx = 0; rd_tid = 0;
      for (int i = 0; i < 256; i++)
         for (int b = 0; b < 4; b++)
            m[i][b] = b_rst(8'(i));
      repeat (3) @(negedge clk);

      // R7 reset values
      for (int t = 0; t < NTC; t++)
         rd_chk("R7 status reset", 8'd96, TW'(t), 32'h00400004);
      rd_chk("R7 random reset", 8'd8, 2'd0, 32'd63);
      rd_chk("R7 ebase reset", 8'd121, 2'd0, 32'h80000000);
      rd_chk("R7 config reset", 8'd128, 2'd2, 32'h80000000);
      rd_chk("R7 cause reset", 8'd104, 2'd0, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rd_chk("R7 debug reset", 8'd184, 2'd3, 32'h0);

      // R8 / R1 masks
      swr(8'd104, 2'd0, 32'hFFFFFFFF);
      rd_chk("R8 cause mask", 8'd104, 2'd0, 32'h08C00300);
      swr(8'd96, 2'd1, 32'hFFFFFFFF);
      rd_chk("R8 status mask", 8'd96, 2'd1, 32'hFF78FF17);
      swr(8'd128, 2'd0, 32'hFFFFFFFF);
      rd_chk("R8 config mask", 8'd128, 2'd0, 32'hFFFF0007);
      swr(8'd128, 2'd0, 32'h0);
      rd_chk("R1 config bit31 kept", 8'd128, 2'd0, 32'h80000000);
      swr(8'd121, 2'd0, 32'hFFFFFFFF);
      rd_chk("R8 ebase mask", 8'd121, 2'd0, 32'hBFFFF000);
      swr(8'd40, 2'd0, 32'hFFFFFFFF);
      rd_chk("R8 pagemask mask", 8'd40, 2'd0, 32'h1FFFF800);

      // R2 read-only registers
      swr(8'd120, 2'd0, 32'hFFFFFFFF);
      rd_chk("R2 prid", 8'd120, 2'd0, 32'h0);
      swr(8'd129, 2'd0, 32'hFFFFFFFF);
      rd_chk("R2 config1", 8'd129, 2'd0, 32'h0);
      swr(8'd131, 2'd0, 32'hFFFFFFFF);
      rd_chk("R2 config3", 8'd131, 2'd0, 32'h0);
      swr(8'd8, 2'd0, 32'h0);
      rd_chk("R2 random", 8'd8, 2'd0, 32'd63);
      swr(8'd64, 2'd0, 32'hFFFFFFFF);
      rd_chk("R2 badaddr", 8'd64, 2'd0, 32'h0);
      swr(8'd136, 2'd2, 32'hFFFFFFFF);
      rd_chk("R2 linkaddr", 8'd136, 2'd2, 32'h0);

      // R3 unused indices
      swr(8'd56, 2'd0, 32'hFFFFFFFF);
      rd_chk("R3 unused 56", 8'd56, 2'd0, 32'h0);
      rd_chk("R3 unused 255", 8'd255, 2'd1, 32'h0);

      // R4 per-thread
      swr(8'd184, 2'd1, 32'h0000A5A5);
      rd_chk("R4 debug own", 8'd184, 2'd1, 32'h0000A5A5);
      rd_chk("R4 debug other", 8'd184, 2'd0, 32'h0);

      // R6 shared
      swr(8'd0, 2'd3, 32'h00000012);
      rd_chk("R6 index shared", 8'd0, 2'd0, 32'h00000012);

      // R5 per-VPE through binding register
      swr(8'd18, 2'd2, 32'h1);
      rd_chk("R5 bind readback", 8'd18, 2'd2, 32'h1);
      swr(8'd9, 2'd2, 32'h77);
      rd_chk("R5 vpe0 untouched", 8'd9, 2'd0, 32'h0);
      rd_chk("R5 vpe1 unbound thread", 8'd9, 2'd3, 32'h0);
      swr(8'd18, 2'd3, 32'h1);
      rd_chk("R5 vpe1 after bind", 8'd9, 2'd3, 32'h77);

      // R9 direct write ignores mask
      cyc(1'b0, 8'd0, 2'd0, 32'h0, 1'b1, 8'd120, 2'd0, 32'hCAFEF00D);
      rd_chk("R9 prid direct", 8'd120, 2'd0, 32'hCAFEF00D);

      // R10 collisions
      cyc(1'b1, 8'd104, 2'd0, 32'hFFFFFFFF, 1'b1, 8'd104, 2'd1, 32'h00000001);
      rd_chk("R10 direct wins", 8'd104, 2'd0, 32'h00000001);
      cyc(1'b1, 8'd0, 2'd0, 32'h5, 1'b1, 8'd112, 2'd0, 32'h9);
      rd_chk("R10 both sw", 8'd0, 2'd1, 32'h5);
      rd_chk("R10 both dw", 8'd112, 2'd2, 32'h9);
      cyc(1'b1, 8'd184, 2'd0, 32'h3, 1'b1, 8'd184, 2'd1, 32'h4);
      rd_chk("R10 diff bank sw", 8'd184, 2'd0, 32'h3);
      rd_chk("R10 diff bank dw", 8'd184, 2'd1, 32'h4);

      // R11 combinational read follows address
      rd_idx = 8'd8; #1;
      check("R11 read follows idx", rd_data, 32'd63);
      rd_idx = 8'd184; rd_tid = 2'd1; #1;
      check("R11 read follows tid", rd_data, 32'h4);

      // random mix, R1/R4/R5/R10
      for (int n = 0; n < 3000; n++) begin
         logic se, de;
         se = ($urandom % 10) < 7;
         de = ($urandom % 10) < 2;
         cyc(se, pick($urandom % 16), TW'($urandom), $urandom,
             de, pick($urandom % 16), TW'($urandom), $urandom);
         begin
            logic [7:0] ri;
            logic [TW-1:0] rt;
            ri = pick($urandom % 16);
            rt = TW'($urandom);
            rd_chk("R1/R5 random", ri, rt, b_read(ri, rt));
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule